// File: doc/BRIEF.md
# Interrupt Presentation Unit

This block sits beside one processor and decides which single interrupt is presented to it. It keeps four pieces of state: the processor's current priority threshold, the priority of a software inter-processor request, the source number now pending together with that source's priority, and a flag recording that an offer was turned away. Priorities are 8-bit numbers where a smaller value is more urgent and 0xFF stands for "nothing pending". Source number 0 means empty, and source number 2 is the fixed code of the inter-processor request.

A source controller offers interrupts (a source number and its priority). The processor issues four commands: accept (read and take the pending interrupt), set the threshold, set the inter-processor request priority, and end-of-interrupt. When a more urgent interrupt displaces the pending one, the displaced source number is sent back on a reject channel for redelivery. When an offer is turned away, the unit remembers it and later raises a one-cycle resend request so the source controller can try again.

Commands are decoded in four named operations: ACCEPT (code 0), SET_CPPR (code 1), SET_MFRR (code 2) and EOI (code 3). A threshold write is classified as a raise (new value numerically larger), a lower (numerically smaller) or same. All state and all pulse outputs are registered; the interrupt line is derived from the registered state.

Top module: `intr_present_unit`

## Requirements
- R1: After reset the threshold is 0x00, the request priority and pending priority are 0xFF, the pending source is 0 and the resend flag is clear; the interrupt line and every pulse output are low, and a first ACCEPT returns 0x00000000.
- R2: An offer with no command in the same cycle is taken only if its priority is strictly less than the threshold, the request priority and the pending priority; it then becomes the pending source and pending priority.
- R3: A displaced source is reported for one cycle on rej_valid/rej_src; a displaced value of 0 or of the request code 2 is never reported, and rej_src reads 0 when rej_valid is low.
- R4: An offer that is not taken sets the resend flag, observed as a later resend_req.
- R5: irq_out is high exactly when the pending source is nonzero and the pending priority is strictly less than the threshold.
- R6: ACCEPT (code 0) returns {threshold[31:24], pending source[23:0]} on acc_data with acc_valid; if the source was nonzero, the threshold takes the pending priority, the pending priority becomes 0xFF and the source clears; otherwise nothing changes.
- R7: A threshold raise (SET_CPPR, code 1, value in cmd_data[7:0]) loads the value; if the request priority is less than the new threshold and at most the pending priority, source 2 becomes pending at the request priority; the resend flag is copied to resend_req and cleared.
- R8: A threshold lower loads the value; if the new threshold is at most the pending priority, the pending source is displaced, the source clears and the pending priority becomes 0xFF. Writing the same value changes nothing.
- R9: SET_MFRR (code 2, value in cmd_data[7:0]) loads the request priority; if the value is less than the threshold and at most the pending priority, the pending source is displaced and source 2 becomes pending at that priority.
- R10: SET_MFRR with a value greater than the previous request priority copies the resend flag to resend_req and clears it.
- R11: EOI (code 3) applies cmd_data[31:24] with the raise rule of R7 whatever its relation to the threshold, and without displacing anything; it forwards cmd_data[23:0] on eoi_valid/eoi_src unless that value is 2.
- R12: When an offer and a command arrive in the same cycle, the command is applied and the offer is not taken, so the resend flag is set after the command.
- R13: Every pulse output and every state change appears in the cycle after the clock edge that samples the stimulus.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| offer_valid | input | 1 | Offer from the source controller |
| offer_src | input | 24 | Offered source number |
| offer_pri | input | 8 | Offered priority |
| cmd_valid | input | 1 | Processor command strobe |
| cmd_op | input | 2 | 0 ACCEPT, 1 SET_CPPR, 2 SET_MFRR, 3 EOI |
| cmd_data | input | 32 | Command operand |
| irq_out | output | 1 | Interrupt line to the processor |
| rej_valid | output | 1 | Displaced source report |
| rej_src | output | 24 | Displaced source number |
| resend_req | output | 1 | One-cycle request to redeliver refused offers |
| acc_valid | output | 1 | ACCEPT result valid |
| acc_data | output | 32 | ACCEPT result {threshold, source} |
| eoi_valid | output | 1 | End-of-interrupt forward to the source controller |
| eoi_src | output | 24 | Source receiving end-of-interrupt |

## Verification
Every pulse result (reject, resend, accept data, end-of-interrupt) is due one edge after the edge that samples the stimulus, and irq_out reflects the new state at that same moment, since it is decoded from the registers. The bench drives inputs on the falling edge, lets one rising edge pass, and compares all outputs one nanosecond later, before the next falling edge removes the stimulus. A reference model in the bench, written from the requirements, is advanced once per stimulus so that every output is checked in exactly that cycle, through a full threshold-by-offer sweep over a set of boundary priorities and a long pseudo-random mix of offers, commands and collisions.

// File: rtl/ipu_pkg.sv
package ipu_pkg;

    typedef enum logic [1:0] {
        OP_ACCEPT   = 2'd0,
        OP_SET_CPPR = 2'd1,
        OP_SET_MFRR = 2'd2,
        OP_EOI      = 2'd3
    } ipu_op_e;

    typedef enum logic [1:0] {
        MOVE_SAME  = 2'd0,
        MOVE_RAISE = 2'd1,
        MOVE_LOWER = 2'd2
    } ipu_move_e;

endpackage

// File: rtl/ipu_offer_eval.sv
module ipu_offer_eval #(
    parameter int PRI_W = 8
) (
    input  logic [PRI_W-1:0] offer_pri,
    input  logic [PRI_W-1:0] cppr,
    input  logic [PRI_W-1:0] mfrr,
    input  logic [PRI_W-1:0] pend,
    output logic             win
);
    always_comb begin
        win = (offer_pri < cppr) && (offer_pri < mfrr) && (offer_pri < pend);
    end
endmodule

// File: rtl/ipu_reject_filter.sv
module ipu_reject_filter #(
    parameter int SRC_W   = 24,
    parameter int IPI_SRC = 2
) (
    input  logic             in_valid,
    input  logic [SRC_W-1:0] in_src,
    output logic             out_valid,
    output logic [SRC_W-1:0] out_src
);
    localparam logic [SRC_W-1:0] SRC_IPI = SRC_W'(IPI_SRC);

    always_comb begin
        out_valid = in_valid && (in_src != '0) && (in_src != SRC_IPI);
        out_src   = out_valid ? in_src : '0;
    end
endmodule

// File: rtl/ipu_cmd_engine.sv
module ipu_cmd_engine
    import ipu_pkg::*;
#(
    parameter int PRI_W   = 8,
    parameter int SRC_W   = 24,
    parameter int IPI_SRC = 2
) (
    input  logic [1:0]             op,
    input  logic [PRI_W+SRC_W-1:0] data,
    input  logic [PRI_W-1:0]       cppr,
    input  logic [PRI_W-1:0]       mfrr,
    input  logic [PRI_W-1:0]       pend,
    input  logic [SRC_W-1:0]       xisr,
    input  logic                   need,
    output logic [PRI_W-1:0]       n_cppr,
    output logic [PRI_W-1:0]       n_mfrr,
    output logic [PRI_W-1:0]       n_pend,
    output logic [SRC_W-1:0]       n_xisr,
    output logic                   n_need,
    output logic                   disp_valid,
    output logic [SRC_W-1:0]       disp_src,
    output logic                   resend,
    output logic                   acc,
    output logic                   eoi
);
    localparam int WORD_W = PRI_W + SRC_W;
    localparam logic [PRI_W-1:0] PRI_NONE = '1;
    localparam logic [SRC_W-1:0] SRC_IPI  = SRC_W'(IPI_SRC);

    ipu_op_e          op_e;
    ipu_move_e        move;
    logic [PRI_W-1:0] wr_val;
    logic [PRI_W-1:0] raise_val;
    logic             raise_ipi;

    always_comb begin
        op_e      = ipu_op_e'(op);
        wr_val    = data[PRI_W-1:0];
        raise_val = (op_e == OP_EOI) ? data[WORD_W-1:SRC_W] : wr_val;
        raise_ipi = (mfrr < raise_val) && (mfrr <= pend);
        if (wr_val > cppr)      move = MOVE_RAISE;
        else if (wr_val < cppr) move = MOVE_LOWER;
        else                    move = MOVE_SAME;
    end

    always_comb begin
        n_cppr     = cppr;
        n_mfrr     = mfrr;
        n_pend     = pend;
        n_xisr     = xisr;
        n_need     = need;
        disp_valid = 1'b0;
        disp_src   = '0;
        resend     = 1'b0;
        acc        = 1'b0;
        eoi        = 1'b0;
        unique case (op_e)
            OP_ACCEPT: begin
                acc = 1'b1;
                if (xisr != '0) begin
                    n_cppr = pend;
                    n_pend = PRI_NONE;
                    n_xisr = '0;
                end
            end
            OP_SET_CPPR: begin
                unique case (move)
                    MOVE_RAISE: begin
                        n_cppr = raise_val;
                        if (raise_ipi) begin
                            n_pend = mfrr;
                            n_xisr = SRC_IPI;
                        end
                        resend = need;
                        n_need = 1'b0;
                    end
                    MOVE_LOWER: begin
                        n_cppr = wr_val;
                        if (wr_val <= pend) begin
                            disp_valid = 1'b1;
                            disp_src   = xisr;
                            n_xisr     = '0;
                            n_pend     = PRI_NONE;
                        end
                    end
                    default: begin
                    end
                endcase
            end
            OP_SET_MFRR: begin
                n_mfrr = wr_val;
                if ((wr_val < cppr) && (wr_val <= pend)) begin
                    disp_valid = 1'b1;
                    disp_src   = xisr;
                    n_pend     = wr_val;
                    n_xisr     = SRC_IPI;
                end
                if (wr_val > mfrr) begin
                    resend = need;
                    n_need = 1'b0;
                end
            end
            OP_EOI: begin
                n_cppr = raise_val;
                if (raise_ipi) begin
                    n_pend = mfrr;
                    n_xisr = SRC_IPI;
                end
                resend = need;
                n_need = 1'b0;
                eoi    = (data[SRC_W-1:0] != SRC_IPI);
            end
        endcase
    end
endmodule

// File: rtl/intr_present_unit.sv
module intr_present_unit #(
    parameter int PRI_W   = 8,
    parameter int SRC_W   = 24,
    parameter int IPI_SRC = 2
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   offer_valid,
    input  logic [SRC_W-1:0]       offer_src,
    input  logic [PRI_W-1:0]       offer_pri,
    input  logic                   cmd_valid,
    input  logic [1:0]             cmd_op,
    input  logic [PRI_W+SRC_W-1:0] cmd_data,
    output logic                   irq_out,
    output logic                   rej_valid,
    output logic [SRC_W-1:0]       rej_src,
    output logic                   resend_req,
    output logic                   acc_valid,
    output logic [PRI_W+SRC_W-1:0] acc_data,
    output logic                   eoi_valid,
    output logic [SRC_W-1:0]       eoi_src
);
    localparam int WORD_W = PRI_W + SRC_W;
    localparam logic [PRI_W-1:0] PRI_NONE = '1;

    logic [PRI_W-1:0] cppr_q, mfrr_q, pend_q;
    logic [SRC_W-1:0] xisr_q;
    logic             need_q;

    logic [PRI_W-1:0] e_cppr, e_mfrr, e_pend;
    logic [SRC_W-1:0] e_xisr, e_disp;
    logic             e_need, e_disp_v, e_resend, e_acc, e_eoi;
    logic             o_win;

    logic [PRI_W-1:0] d_cppr, d_mfrr, d_pend;
    logic [SRC_W-1:0] d_xisr, d_disp;
    logic             d_need, d_disp_v, d_resend, d_acc, d_eoi;
    logic             f_valid;
    logic [SRC_W-1:0] f_src;

    ipu_cmd_engine #(.PRI_W(PRI_W), .SRC_W(SRC_W), .IPI_SRC(IPI_SRC)) u_engine (
        .op(cmd_op), .data(cmd_data),
        .cppr(cppr_q), .mfrr(mfrr_q), .pend(pend_q), .xisr(xisr_q), .need(need_q),
        .n_cppr(e_cppr), .n_mfrr(e_mfrr), .n_pend(e_pend), .n_xisr(e_xisr), .n_need(e_need),
        .disp_valid(e_disp_v), .disp_src(e_disp), .resend(e_resend), .acc(e_acc), .eoi(e_eoi)
    );

    ipu_offer_eval #(.PRI_W(PRI_W)) u_offer (
        .offer_pri(offer_pri), .cppr(cppr_q), .mfrr(mfrr_q), .pend(pend_q), .win(o_win)
    );

    ipu_reject_filter #(.SRC_W(SRC_W), .IPI_SRC(IPI_SRC)) u_filter (
        .in_valid(d_disp_v), .in_src(d_disp), .out_valid(f_valid), .out_src(f_src)
    );

    always_comb begin
        d_cppr   = cppr_q;
        d_mfrr   = mfrr_q;
        d_pend   = pend_q;
        d_xisr   = xisr_q;
        d_need   = need_q;
        d_disp_v = 1'b0;
        d_disp   = '0;
        d_resend = 1'b0;
        d_acc    = 1'b0;
        d_eoi    = 1'b0;
        if (cmd_valid) begin
            d_cppr   = e_cppr;
            d_mfrr   = e_mfrr;
            d_pend   = e_pend;
            d_xisr   = e_xisr;
            d_need   = e_need | offer_valid;
            d_disp_v = e_disp_v;
            d_disp   = e_disp;
            d_resend = e_resend;
            d_acc    = e_acc;
            d_eoi    = e_eoi;
        end else if (offer_valid) begin
            if (o_win) begin
                d_disp_v = 1'b1;
                d_disp   = xisr_q;
                d_xisr   = offer_src;
                d_pend   = offer_pri;
            end else begin
                d_need = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cppr_q <= '0;
            mfrr_q <= PRI_NONE;
            pend_q <= PRI_NONE;
            xisr_q <= '0;
            need_q <= 1'b0;
        end else begin
            cppr_q <= d_cppr;
            mfrr_q <= d_mfrr;
            pend_q <= d_pend;
            xisr_q <= d_xisr;
            need_q <= d_need;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rej_valid  <= 1'b0;
            rej_src    <= '0;
            resend_req <= 1'b0;
            acc_valid  <= 1'b0;
            acc_data   <= '0;
            eoi_valid  <= 1'b0;
            eoi_src    <= '0;
        end else begin
            rej_valid  <= f_valid;
            rej_src    <= f_src;
            resend_req <= d_resend;
            acc_valid  <= d_acc;
            acc_data   <= d_acc ? {cppr_q, xisr_q} : WORD_W'(0);
            eoi_valid  <= d_eoi;
            eoi_src    <= d_eoi ? cmd_data[SRC_W-1:0] : '0;
        end
    end

    always_comb begin
        irq_out = (xisr_q != '0) && (pend_q < cppr_q);
    end
endmodule

// File: rtl/ipu_checker.sv
module ipu_checker #(
    parameter int PRI_W   = 8,
    parameter int SRC_W   = 24,
    parameter int IPI_SRC = 2
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic                   offer_valid,
    input logic                   cmd_valid,
    input logic [1:0]             cmd_op,
    input logic                   irq_out,
    input logic                   rej_valid,
    input logic [SRC_W-1:0]       rej_src,
    input logic                   resend_req,
    input logic                   acc_valid,
    input logic [PRI_W+SRC_W-1:0] acc_data,
    input logic                   eoi_valid,
    input logic [SRC_W-1:0]       eoi_src
);
    localparam logic [SRC_W-1:0] SRC_IPI = SRC_W'(IPI_SRC);

    p_reject_filtered_r3: assert property (@(posedge clk) disable iff (!rst_n)
        rej_valid |-> (rej_src != '0) && (rej_src != SRC_IPI));

    p_accept_drops_line_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && (acc_data[SRC_W-1:0] != '0)) |-> !irq_out);

    p_accept_cause_r6: assert property (@(posedge clk) disable iff (!rst_n)
        acc_valid |-> $past(cmd_valid && (cmd_op == 2'd0)));

    p_resend_cause_r10: assert property (@(posedge clk) disable iff (!rst_n)
        resend_req |-> $past(cmd_valid && (cmd_op != 2'd0)));

    p_eoi_filtered_r11: assert property (@(posedge clk) disable iff (!rst_n)
        eoi_valid |-> (eoi_src != SRC_IPI));

    p_reject_latency_r13: assert property (@(posedge clk) disable iff (!rst_n)
        rej_valid |-> $past(offer_valid || cmd_valid));
endmodule

bind intr_present_unit ipu_checker #(.PRI_W(PRI_W), .SRC_W(SRC_W), .IPI_SRC(IPI_SRC)) u_chk (
    .clk(clk), .rst_n(rst_n), .offer_valid(offer_valid), .cmd_valid(cmd_valid),
    .cmd_op(cmd_op), .irq_out(irq_out), .rej_valid(rej_valid), .rej_src(rej_src),
    .resend_req(resend_req), .acc_valid(acc_valid), .acc_data(acc_data),
    .eoi_valid(eoi_valid), .eoi_src(eoi_src)
);

// File: tb/intr_present_unit_test.sv
`timescale 1ns/1ps
module intr_present_unit_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        offer_valid = 1'b0;
    logic [23:0] offer_src = '0;
    logic [7:0]  offer_pri = '0;
    logic        cmd_valid = 1'b0;
    logic [1:0]  cmd_op = '0;
    logic [31:0] cmd_data = '0;
    logic        irq_out, rej_valid, resend_req, acc_valid, eoi_valid;
    logic [23:0] rej_src, eoi_src;
    logic [31:0] acc_data;

    int n_checks = 0;
    int n_fails  = 0;
    bit done = 1'b0;

    logic [7:0]  m_cppr, m_mfrr, m_pend;
    logic [23:0] m_xisr;
    logic        m_need;
    logic        e_rv, e_rsnd, e_av, e_ev;
    logic [23:0] e_rsrc, e_esrc;
    logic [31:0] e_adata;
    logic [31:0] lfsr = 32'h1bad5eed;

    logic [7:0] pset [8];

    always #2.5 clk = ~clk;

    intr_present_unit uut (
        .clk(clk), .rst_n(rst_n), .offer_valid(offer_valid), .offer_src(offer_src),
        .offer_pri(offer_pri), .cmd_valid(cmd_valid), .cmd_op(cmd_op), .cmd_data(cmd_data),
        .irq_out(irq_out), .rej_valid(rej_valid), .rej_src(rej_src), .resend_req(resend_req),
        .acc_valid(acc_valid), .acc_data(acc_data), .eoi_valid(eoi_valid), .eoi_src(eoi_src)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic model_raise(input logic [7:0] v);
        m_cppr = v;
        if ((m_mfrr < v) && (m_mfrr <= m_pend)) begin
            m_pend = m_mfrr;
            m_xisr = 24'd2;
        end
        e_rsnd = m_need;
        m_need = 1'b0;
    endtask

    task automatic model(input bit ov, input logic [23:0] os, input logic [7:0] op_pri,
                         input bit cv, input logic [1:0] op, input logic [31:0] d);
        logic        dv;
        logic [23:0] disp;
        logic [7:0]  v, old;
        dv = 1'b0; disp = '0;
        e_rsnd = 1'b0; e_av = 1'b0; e_adata = '0; e_ev = 1'b0; e_esrc = '0;
        v = d[7:0];
        if (cv) begin
            case (op)
                2'd0: begin
                    e_av = 1'b1; e_adata = {m_cppr, m_xisr};
                    if (m_xisr != 0) begin
                        m_cppr = m_pend; m_pend = 8'hFF; m_xisr = '0;
                    end
                end
                2'd1: begin
                    if (v > m_cppr) model_raise(v);
                    else if (v < m_cppr) begin
                        m_cppr = v;
                        if (v <= m_pend) begin
                            dv = 1'b1; disp = m_xisr; m_xisr = '0; m_pend = 8'hFF;
                        end
                    end
                end
                2'd2: begin
                    old = m_mfrr; m_mfrr = v;
                    if ((v < m_cppr) && (v <= m_pend)) begin
                        dv = 1'b1; disp = m_xisr; m_pend = v; m_xisr = 24'd2;
                    end
                    if (v > old) begin
                        e_rsnd = m_need; m_need = 1'b0;
                    end
                end
                default: begin
                    model_raise(d[31:24]);
                    e_ev = (d[23:0] != 24'd2);
                    e_esrc = e_ev ? d[23:0] : '0;
                end
            endcase
            if (ov) m_need = 1'b1;
        end else if (ov) begin
            if ((op_pri < m_cppr) && (op_pri < m_mfrr) && (op_pri < m_pend)) begin
                dv = 1'b1; disp = m_xisr; m_xisr = os; m_pend = op_pri;
            end else begin
                m_need = 1'b1;
            end
        end
        e_rv   = dv && (disp != 0) && (disp != 24'd2);
        e_rsrc = e_rv ? disp : '0;
    endtask

    task automatic step(input bit ov, input logic [23:0] os, input logic [7:0] op_pri,
                        input bit cv, input logic [1:0] op, input logic [31:0] d);
        string t;
        offer_valid = ov; offer_src = os; offer_pri = op_pri;
        cmd_valid = cv; cmd_op = op; cmd_data = d;
        model(ov, os, op_pri, cv, op, d);
        @(posedge clk);
        #1;
        if (cv && ov) t = "R12";
        else if (!cv) t = "R2";
        else case (op)
            2'd0: t = "R6";
            2'd1: t = "R7/R8";
            2'd2: t = "R9/R10";
            default: t = "R11";
        endcase
        check({t, " R5 irq"}, 32'(irq_out), 32'(m_xisr != 0 && m_pend < m_cppr));
        check({t, " R3 reject"}, {7'd0, rej_valid, rej_src}, {7'd0, e_rv, e_rsrc});
        check({t, " R4 R10 resend"}, 32'(resend_req), 32'(e_rsnd));
        check({t, " R6 accept"}, acc_valid ? acc_data : 32'hDEAD0000, e_av ? e_adata : 32'hDEAD0000);
        check({t, " R11 eoi"}, {7'd0, eoi_valid, eoi_src}, {7'd0, e_ev, e_esrc});
        @(negedge clk);
        offer_valid = 1'b0; cmd_valid = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fails++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
            $finish;
        end
    end

    initial begin
        pset[0] = 8'h00; pset[1] = 8'h01; pset[2] = 8'h02; pset[3] = 8'h04;
        pset[4] = 8'h05; pset[5] = 8'h08; pset[6] = 8'hFE; pset[7] = 8'hFF;
        m_cppr = 8'h00; m_mfrr = 8'hFF; m_pend = 8'hFF; m_xisr = '0; m_need = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        // R1: reset state
        check("R1 irq", 32'(irq_out), 0);
        check("R1 pulses", {28'd0, rej_valid, resend_req, acc_valid, eoi_valid}, 0);
        @(negedge clk);
        step(0, 0, 0, 1, 2'd0, 0);
        check("R1 first accept", acc_data, 32'h0000_0000);
        // directed walk
        step(0, 0, 0, 1, 2'd1, 32'hFF);                 // R7 raise to FF
        step(1, 24'h10, 8'h05, 0, 0, 0);                 // R2 accepted
        check("R5 line high", 32'(irq_out), 1);
        step(1, 24'h11, 8'h05, 0, 0, 0);                 // R2 equal refused, R4 flag
        check("R2 equal refused", 32'(rej_valid), 0);
        step(1, 24'h12, 8'h03, 0, 0, 0);                 // R3 displaces 0x10
        check("R3 displaced", rej_src, 32'h10);
        step(0, 0, 0, 1, 2'd2, 32'h01);                  // R9 IPI preempts 0x12
        check("R9 displaced", rej_src, 32'h12);
        step(0, 0, 0, 1, 2'd0, 0);                       // R6
        check("R6 accept ipi", acc_data, 32'hFF00_0002);
        check("R6 line low", 32'(irq_out), 0);
        step(0, 0, 0, 1, 2'd2, 32'hFF);                  // R10 resend from earlier refusal
        check("R10 resend", 32'(resend_req), 1);
        step(0, 0, 0, 1, 2'd3, 32'hFF00_0002);           // R11 IPI code not forwarded
        check("R11 ipi eoi", 32'(eoi_valid), 0);
        step(0, 0, 0, 1, 2'd3, 32'hFF00_0033);           // R11 forwarded
        check("R11 eoi src", eoi_src, 32'h33);
        step(0, 0, 0, 1, 2'd1, 32'hFF);                  // R8 same value no effect
        step(1, 24'h20, 8'h04, 1, 2'd0, 0);              // R12 collision
        check("R12 not taken", 32'(irq_out), 0);
        // sweep threshold x offer priority
        for (int a = 0; a < 8; a++) begin
            for (int b = 0; b < 8; b++) begin
                step(0, 0, 0, 1, 2'd1, 32'(pset[a]));
                step(1, 24'h40 + 24'(b), pset[b], 0, 0, 0);
                step(0, 0, 0, 1, 2'd0, 0);
                step(0, 0, 0, 1, 2'd3, {pset[7 - a], 24'h40 + 24'(b)});
            end
        end
        // pseudo-random mix
        for (int i = 0; i < 6000; i++) begin
            logic [23:0] s;
            logic [31:0] d;
            lfsr = lfsr ^ (lfsr << 13);
            lfsr = lfsr ^ (lfsr >> 17);
            lfsr = lfsr ^ (lfsr << 5);
            s = 24'h10 + 24'(lfsr[10:8]);
            if (lfsr[3:2] == 2'd3) d = {pset[lfsr[13:11]], (lfsr[7] ? 24'd2 : s)};
            else d = 32'(pset[lfsr[16:14]]);
            step(lfsr[0], s, pset[lfsr[6:4]], lfsr[1], lfsr[3:2], d);
        end
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
        $finish;
    end
endmodule